// File: doc/BRIEF.md
# Rail Voltage Window Supervisor

This block supervises a single power rail from a stream of 12-bit converter samples. Each sample that arrives with its valid strobe is compared against four programmable limits: an over-voltage fault limit, an over-voltage warning limit, an under-voltage fault limit and an under-voltage warning limit. Two timers, driven by an external time-base tick, check that an enabled rail reaches its power-good level within a turn-on budget. They also check that a disabled rail decays below one eighth of its nominal value within a turn-off budget.

Every detected condition sets a sticky status bit, and the alert output is high while any status bit is set. Fault detections also raise a one-cycle log request. Warnings never raise one. A per-input glitch filter stands between the voltage-fault detection and the fault-event output that feeds a downstream response controller. The filter delays only that output. The alert, status and log request always react at once. The converter, host bus decoding and non-volatile logging sit outside this block.

Top module: `rail_window_sup`

## Requirements
- R1: After a synchronous active-low reset, `status` is 0 and `alert`, `log_req` and `flt_event` are low.
- R2: Over-voltage checks are active whether or not power-good has been reached. A sample strictly above `ov_flt_lim` sets status bit 0, and a sample strictly above `ov_warn_lim` sets status bit 1.
- R3: Under-voltage checks are armed only after a sample at or above `pg_on_lim` has been seen while `rail_en` is high, and they are disarmed while `rail_en` is low. Once armed, a sample strictly below `uv_flt_lim` sets status bit 2, and a sample strictly below `uv_warn_lim` sets status bit 3.
- R4: Samples are evaluated only in cycles where `smp_vld` is high. The resulting status is visible in the cycle after the sample.
- R5: `alert` is high whenever any status bit is set. This holds in the cycle after the sample, whatever the glitch-filter setting.
- R6: Status bits are sticky. Samples back inside the window do not clear them. A one-cycle `clr_status` clears them all, and `alert` then falls.
- R7: `log_req` pulses for one cycle when a fault condition is detected whose status bit is still clear. The fault conditions are status bits 0, 2 and 4. Warnings (bits 1, 3 and 5) never cause a pulse.
- R8: While `rail_en` is high and power-good has not been reached, ticks are counted. Once `ton_max` ticks have been counted, status bit 4 (turn-on fault) is set, and `log_req` and `flt_event` pulse once.
- R9: A falling edge of `rail_en` starts a turn-off watch. It ends early on a sample strictly below `nominal >> 3`. Otherwise, after `toff_max` ticks, status bit 5 (turn-off warning) is set.
- R10: With `filt_en` low, `flt_event` pulses two cycles after an over- or under-voltage fault sample. With `filt_en` high, the pulse comes only after `filt_len` ticks of a continuous excursion. Any sample inside the fault window restarts the count.
- R11: Each voltage-fault excursion gives at most one `flt_event` pulse. Another pulse needs a sample inside the fault window first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample-valid strobe |
| smp_data | input | 12 | Converter sample |
| rail_en | input | 1 | Rail enable command |
| ov_flt_lim | input | 12 | Over-voltage fault limit |
| ov_warn_lim | input | 12 | Over-voltage warning limit |
| uv_warn_lim | input | 12 | Under-voltage warning limit |
| uv_flt_lim | input | 12 | Under-voltage fault limit |
| pg_on_lim | input | 12 | Power-good-on level |
| nominal | input | 12 | Nominal rail value |
| ton_max | input | 16 | Turn-on budget in ticks |
| toff_max | input | 16 | Turn-off budget in ticks |
| filt_en | input | 1 | Glitch filter enable |
| filt_len | input | 8 | Glitch filter length in ticks |
| tick | input | 1 | Time-base tick |
| clr_status | input | 1 | Clear all status bits |
| status | output | 6 | Sticky condition bits |
| alert | output | 1 | Any condition flagged |
| log_req | output | 1 | Fault log request pulse |
| flt_event | output | 1 | Filtered fault event pulse |

## Verification
Some internal state errors would not show on the status bits at all. A power-good flag that is stuck at zero hides every under-voltage sample, so the status stays clear where bits 2 and 3 were expected. A stuck-high flag flags startup samples that should have been ignored. Either error shows one cycle after the sample.

Timer and filter errors show on the event outputs instead. A filter counter that is not restarted by an in-window sample lets `flt_event` fire too early. A confirm flag that never clears loses the event of the next excursion. Both are seen within a few cycles of the deciding tick. A turn-off watch that is not cancelled by a low sample sets bit 5 after the budget expires.

// File: rtl/rws_pkg.sv
// Shared definitions for the rail window supervisor.
// Assumes: status vector layout below is decoded by software and the bench.
package rws_pkg;
    localparam int ST_W    = 6;
    localparam int ST_OVF  = 0;  // over-voltage fault
    localparam int ST_OVW  = 1;  // over-voltage warning
    localparam int ST_UVF  = 2;  // under-voltage fault
    localparam int ST_UVW  = 3;  // under-voltage warning
    localparam int ST_TON  = 4;  // turn-on timeout fault
    localparam int ST_TOFF = 5;  // turn-off timeout warning

    localparam logic [ST_W-1:0] FAULT_MASK = 6'b010101;
endpackage

// File: rtl/rws_compare.sv
// Limit comparator for one sample.
// Assumes: limits are stable; outputs are only meaningful with smp_vld,
// and are gated by it here. Under-voltage results are gated by pg_armed.
module rws_compare #(
    parameter int ADC_W = 12
) (
    input  logic             smp_vld,
    input  logic [ADC_W-1:0] smp_data,
    input  logic             pg_armed,
    input  logic [ADC_W-1:0] ov_flt_lim,
    input  logic [ADC_W-1:0] ov_warn_lim,
    input  logic [ADC_W-1:0] uv_warn_lim,
    input  logic [ADC_W-1:0] uv_flt_lim,
    input  logic [ADC_W-1:0] pg_on_lim,
    input  logic [ADC_W-1:0] nominal,
    output logic             det_ovf,
    output logic             det_ovw,
    output logic             det_uvf,
    output logic             det_uvw,
    output logic             det_pg,
    output logic             det_low
);
    localparam int LOW_SHIFT = 3;

    logic [ADC_W-1:0] low_lim;

    // Derive the decay threshold as one eighth of nominal.
    always_comb begin
        low_lim = nominal >> LOW_SHIFT;
    end

    // Compare the sample against every limit, qualified by the strobe.
    always_comb begin
        det_ovf = smp_vld && (smp_data > ov_flt_lim);
        det_ovw = smp_vld && (smp_data > ov_warn_lim);
        det_uvf = smp_vld && pg_armed && (smp_data < uv_flt_lim);
        det_uvw = smp_vld && pg_armed && (smp_data < uv_warn_lim);
        det_pg  = smp_vld && (smp_data >= pg_on_lim);
        det_low = smp_vld && (smp_data < low_lim);
    end
endmodule

// File: rtl/rws_timeout.sv
// Tick-driven timeout: while run is high, ticks are counted; hit pulses
// once when the count reaches limit. Dropping run restarts it.
// Assumes: tick is a single-cycle strobe.
module rws_timeout #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             hit
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_q;
    logic             done_q;

    // Fire once when the counted ticks reach the budget.
    always_comb begin
        hit = run && !done_q && (cnt_q >= limit);
    end

    // Count ticks while running; restart when the watch stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (hit) done_q <= 1'b1;
        end
    end

    AST_TMO_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R8
endmodule

// File: rtl/rws_glitch.sv
// Glitch filter on the voltage-fault window. An out-of-window sample
// opens an excursion; ticks are counted until filt_len, then one event
// pulse is issued. An in-window sample ends the excursion and rearms.
// Assumes: tick is a single-cycle strobe.
module rws_glitch #(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic              out_win,
    input  logic              tick,
    input  logic              filt_en,
    input  logic [FILT_W-1:0] filt_len,
    output logic              fe_pulse
);
    localparam logic [FILT_W-1:0] CNT_MAX = '1;

    logic              out_q;
    logic              conf_q;
    logic [FILT_W-1:0] cnt_q;
    logic              fire;

    // Decide whether the excursion has lasted long enough.
    always_comb begin
        fire = out_q && !conf_q && (!filt_en || cnt_q >= filt_len);
    end

    // Track excursion state, its duration and whether it was reported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            conf_q   <= 1'b0;
            cnt_q    <= '0;
            fe_pulse <= 1'b0;
        end else begin
            fe_pulse <= fire;
            if (fire) conf_q <= 1'b1;
            if (smp_vld) out_q <= out_win;
            if (smp_vld && !out_win) begin
                cnt_q  <= '0;
                conf_q <= 1'b0;
            end else if (out_q && tick && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_FE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fe_pulse |=> !fe_pulse); // R11
endmodule

// File: rtl/rail_window_sup.sv
// Rail voltage window supervisor top level.
// Holds power-good arming, turn-off watch, sticky status, alert, log
// request and fault-event merge. Assumes synchronous active-low reset
// and a single clock domain for all inputs.
module rail_window_sup
    import rws_pkg::*;
#(
    parameter int ADC_W  = 12,
    parameter int TMO_W  = 16,
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [ADC_W-1:0]  smp_data,
    input  logic              rail_en,
    input  logic [ADC_W-1:0]  ov_flt_lim,
    input  logic [ADC_W-1:0]  ov_warn_lim,
    input  logic [ADC_W-1:0]  uv_warn_lim,
    input  logic [ADC_W-1:0]  uv_flt_lim,
    input  logic [ADC_W-1:0]  pg_on_lim,
    input  logic [ADC_W-1:0]  nominal,
    input  logic [TMO_W-1:0]  ton_max,
    input  logic [TMO_W-1:0]  toff_max,
    input  logic              filt_en,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              tick,
    input  logic              clr_status,
    output logic [ST_W-1:0]   status,
    output logic              alert,
    output logic              log_req,
    output logic              flt_event
);
    logic            pg_q;
    logic            en_q;
    logic            off_pend_q;
    logic            ton_evt_q;
    logic [ST_W-1:0] status_q;
    logic            log_q;
    logic [ST_W-1:0] set_vec;
    logic            det_ovf, det_ovw, det_uvf, det_uvw, det_pg, det_low;
    logic            ton_hit, toff_hit, glitch_fe;
    logic            ton_run, toff_run;

    rws_compare #(.ADC_W(ADC_W)) u_cmp (
        .smp_vld(smp_vld), .smp_data(smp_data), .pg_armed(pg_q),
        .ov_flt_lim(ov_flt_lim), .ov_warn_lim(ov_warn_lim),
        .uv_warn_lim(uv_warn_lim), .uv_flt_lim(uv_flt_lim),
        .pg_on_lim(pg_on_lim), .nominal(nominal),
        .det_ovf(det_ovf), .det_ovw(det_ovw), .det_uvf(det_uvf),
        .det_uvw(det_uvw), .det_pg(det_pg), .det_low(det_low)
    );

    // Select when each timeout watch is running.
    always_comb begin
        ton_run  = rail_en && !pg_q;
        toff_run = off_pend_q && !rail_en;
    end

    rws_timeout #(.TMO_W(TMO_W)) u_ton (
        .clk(clk), .rst_n(rst_n), .run(ton_run), .tick(tick),
        .limit(ton_max), .hit(ton_hit)
    );

    rws_timeout #(.TMO_W(TMO_W)) u_toff (
        .clk(clk), .rst_n(rst_n), .run(toff_run), .tick(tick),
        .limit(toff_max), .hit(toff_hit)
    );

    rws_glitch #(.FILT_W(FILT_W)) u_flt (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .out_win(det_ovf || det_uvf), .tick(tick),
        .filt_en(filt_en), .filt_len(filt_len), .fe_pulse(glitch_fe)
    );

    // Gather this cycle's detections in status-bit order.
    always_comb begin
        set_vec          = '0;
        set_vec[ST_OVF]  = det_ovf;
        set_vec[ST_OVW]  = det_ovw;
        set_vec[ST_UVF]  = det_uvf;
        set_vec[ST_UVW]  = det_uvw;
        set_vec[ST_TON]  = ton_hit;
        set_vec[ST_TOFF] = toff_hit;
    end

    // Arm under-voltage checks on power-good; disarm when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !rail_en) pg_q <= 1'b0;
        else if (det_pg)        pg_q <= 1'b1;
    end

    // Open the turn-off watch on a disable edge; close on decay or re-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            off_pend_q <= 1'b0;
        end else begin
            en_q <= rail_en;
            if (rail_en || det_low)  off_pend_q <= 1'b0;
            else if (en_q)           off_pend_q <= 1'b1;
        end
    end

    // Keep sticky status, first-fault log request and turn-on event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            log_q     <= 1'b0;
            ton_evt_q <= 1'b0;
        end else begin
            status_q  <= (clr_status ? '0 : status_q) | set_vec;
            log_q     <= |(set_vec & FAULT_MASK & ~status_q);
            ton_evt_q <= ton_hit;
        end
    end

    // Drive the outputs from registered state.
    always_comb begin
        status    = status_q;
        alert     = |status_q;
        log_req   = log_q;
        flt_event = glitch_fe || ton_evt_q;
    end

    AST_UV_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[ST_UVW]) |-> $past(pg_q)); // R3
    AST_LOG_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        log_q |-> |(status_q & FAULT_MASK)); // R7
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && set_vec == '0) |=> (status_q == '0)); // R6
    AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        det_ovf |=> status_q[ST_OVF]); // R2
endmodule

// File: tb/rail_window_sup_tb.sv
`timescale 1ns/1ps
module rail_window_sup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_data = '0;
    logic        rail_en = 1'b0;
    logic [11:0] ov_flt_lim = 12'd3200, ov_warn_lim = 12'd3000;
    logic [11:0] uv_warn_lim = 12'd1200, uv_flt_lim = 12'd1000;
    logic [11:0] pg_on_lim = 12'd1500, nominal = 12'd2000;
    logic [15:0] ton_max = 16'd100, toff_max = 16'd100;
    logic        filt_en = 1'b0;
    logic [7:0]  filt_len = 8'd0;
    logic        tick = 1'b0;
    logic        clr_status = 1'b0;
    logic [5:0]  status;
    logic        alert, log_req, flt_event;

    int errors = 0;
    int checks = 0;
    int log_cnt = 0;
    int fe_cnt = 0;
    int l0, f0;

    always #2.5 clk = ~clk;

    rail_window_sup u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .rail_en(rail_en), .ov_flt_lim(ov_flt_lim), .ov_warn_lim(ov_warn_lim),
        .uv_warn_lim(uv_warn_lim), .uv_flt_lim(uv_flt_lim),
        .pg_on_lim(pg_on_lim), .nominal(nominal), .ton_max(ton_max),
        .toff_max(toff_max), .filt_en(filt_en), .filt_len(filt_len),
        .tick(tick), .clr_status(clr_status), .status(status),
        .alert(alert), .log_req(log_req), .flt_event(flt_event)
    );

    // Pulse counters: read pre-edge values at each rising edge.
    always @(posedge clk) begin
        if (rst_n && log_req)   log_cnt <= log_cnt + 1;
        if (rst_n && flt_event) fe_cnt  <= fe_cnt + 1;
    end

    // {sample, expected status, expected log pulses}, rail on and armed
    localparam logic [18:0] VEC [0:9] = '{
        {12'd2000, 6'b000000, 1'b0},
        {12'd3100, 6'b000010, 1'b0},
        {12'd3300, 6'b000011, 1'b1},
        {12'd1100, 6'b001000, 1'b0},
        {12'd900,  6'b001100, 1'b1},
        {12'd3000, 6'b000000, 1'b0},
        {12'd1200, 6'b000000, 1'b0},
        {12'd1000, 6'b001000, 1'b0},
        {12'd4095, 6'b000011, 1'b1},
        {12'd0,    6'b001100, 1'b1}
    };

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input logic [11:0] v);
        smp_vld = 1'b1;
        smp_data = v;
        cyc(1);
        smp_vld = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
        end
    endtask

    task automatic clear();
        clr_status = 1'b1;
        cyc(1);
        clr_status = 1'b0;
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(3);
        // R1 reset state
        chk("R1 status", status, 0);
        chk("R1 alert", alert, 0);
        chk("R1 log_req", log_req, 0);
        chk("R1 flt_event", flt_event, 0);
        rst_n = 1'b1;
        cyc(1);

        // R4: strobe low, out-of-range data ignored
        smp_data = 12'd4095;
        cyc(2);
        chk("R4 no strobe", status, 0);

        // R3: under-voltage ignored before power-good
        rail_en = 1'b1;
        sample(12'd900);
        chk("R3 unarmed", status, 0);
        // R2: over-voltage active during startup
        sample(12'd3300);
        chk("R2 startup ov", status, 6'b000011);
        chk("R5 alert", alert, 1);
        clear();
        chk("R6 cleared", status, 0);
        chk("R6 alert low", alert, 0);
        sample(12'd2000);

        // Vector table with rail armed
        for (int k = 0; k < 10; k++) begin
            clear();
            l0 = log_cnt;
            sample(VEC[k][18:7]);
            chk("R2/R3 status", status, VEC[k][6:1]);
            chk("R5 alert", alert, |VEC[k][6:1]);
            cyc(2);
            chk("R7 log", log_cnt - l0, VEC[k][0]);
        end

        // R6: sticky through in-window sample
        sample(12'd2000);
        chk("R6 sticky", status, 6'b001100);
        sample(12'd2000);
        cyc(3);

        // R8 turn-on timeout
        toff_max = 16'd100;
        rail_en = 1'b0;
        cyc(1);
        rail_en = 1'b1;
        ton_max = 16'd4;
        clear();
        l0 = log_cnt; f0 = fe_cnt;
        ticks(3);
        cyc(2);
        chk("R8 early", status[4], 0);
        ticks(1);
        cyc(2);
        chk("R8 ton bit", status[4], 1);
        cyc(2);
        chk("R8 log", log_cnt - l0, 1);
        chk("R8 event", fe_cnt - f0, 1);
        sample(12'd2000);

        // R9 turn-off timeout, warning only
        toff_max = 16'd3;
        clear();
        l0 = log_cnt;
        rail_en = 1'b0;
        cyc(1);
        sample(12'd1000);
        ticks(3);
        cyc(2);
        chk("R9 toff bit", status, 6'b100000);
        cyc(2);
        chk("R7 warn no log", log_cnt - l0, 0);

        // R9 decay below nominal>>3 cancels the watch
        rail_en = 1'b1;
        sample(12'd2000);
        clear();
        rail_en = 1'b0;
        cyc(1);
        sample(12'd200);
        ticks(5);
        cyc(2);
        chk("R9 cancelled", status, 0);

        // R10 glitch filter enabled
        rail_en = 1'b1;
        sample(12'd2000);
        filt_en = 1'b1;
        filt_len = 8'd3;
        clear();
        l0 = log_cnt; f0 = fe_cnt;
        sample(12'd3300);
        chk("R5 alert unfiltered", alert, 1);
        ticks(2);
        cyc(3);
        chk("R10 held", fe_cnt - f0, 0);
        chk("R10 log despite filter", log_cnt - l0, 1);
        sample(12'd2000);
        ticks(5);
        cyc(3);
        chk("R10 restart", fe_cnt - f0, 0);
        sample(12'd3300);
        ticks(3);
        cyc(3);
        chk("R10 filtered event", fe_cnt - f0, 1);
        ticks(4);
        cyc(3);
        chk("R11 single", fe_cnt - f0, 1);
        sample(12'd2000);

        // R10 filter disabled: event two cycles after sample
        filt_en = 1'b0;
        f0 = fe_cnt;
        sample(12'd900);
        cyc(1);
        chk("R10 direct", flt_event, 1);
        cyc(2);
        chk("R11 count", fe_cnt - f0, 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule